// File: doc/BRIEF.md
# Event State Buffer Page Controller

This block serves a paged memory-mapped window in which software reads and writes the two-bit pending/queued state of interrupt event queues. Each queue owns two adjacent pages. The lower page holds the state that gates notifications. The upper page holds the state that gates escalations. The address selects the queue and the page. The low twelve address bits pick the operation: trigger, end-of-interrupt, query, forced set, or inject. The state words are kept in an internal array.

Each request is a single 8-byte load or store presented for one cycle. Exactly one cycle later the block returns a response, made of a valid flag, an error flag and 64-bit load data. In that same cycle it may raise a one-cycle notify pulse carrying the queue index and the page that fired. Encodings in this brief: bit 1 of a state word is P and bit 0 is Q. On load data, the state sits in bits [1:0] and all other bits are zero.

Top module: `esb_mmio_ctrl`

## Requirements
- R1: After reset every state word of every queue and page is 00. Neither a response nor a notify is pending.
- R2: A request in cycle n gives `rspValid` high in cycle n+1 only. `rspData` is zero for every accepted store.
- R3: The queue index is `reqAddr >> (PAGE_SHIFT+1)`. Address bit PAGE_SHIFT selects the notification word when 0 and the escalation word when 1. The two words of a queue and the words of different queues are independent.
- R4: A load at offset 0x000–0x7FF performs end-of-interrupt with these transitions: 00→00, 01→01, 10→00, 11→10. It returns 1 in bit 0 exactly when the old state was 11, and in that case it raises a notify.
- R5: A load at offset 0x800–0xBFF returns the current state and changes nothing.
- R6: A load at offset 0xC00–0xFFF sets the state to offset bits [9:8] and returns the old state.
- R7: A store at offset 0x000–0x3FF triggers with these transitions: 00→10 with a notify, 10→11, 01→01, 11→11. Only the first of these notifies.
- R8: A store at offset 0x400–0x7FF performs end-of-interrupt as in R4, with a notify when the old state was 11.
- R9: A store at offset 0x800–0xBFF on a notification page raises a notify and leaves the state unchanged.
- R10: A store at offset 0x800–0xBFF on an escalation page is an error. It raises no notify and changes no state.
- R11: Any of the following is an error: a queue index of NUM_QUEUES or above, a queue whose `qEnable` bit is 0, an access size other than 8 bytes, or a store at offset 0xC00–0xFFF. An erroneous load returns all ones. An erroneous access changes no state and raises no notify.
- R12: PAGE_SHIFT may be 12 or 16 and stops elaboration otherwise. The offset is always taken from address bits [11:0].
- R13: `notifyQueue` and `notifyEsc` give the queue index and the page of the access that raised the notify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qEnable | input | NUM_QUEUES | Per-queue valid bits |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqBytes | input | 4 | Access size in bytes |
| reqAddr | input | ADDR_W | Byte address within the window |
| rspValid | output | 1 | Response valid |
| rspErr | output | 1 | Access refused |
| rspData | output | 64 | Load result |
| notifyValid | output | 1 | Notify pulse |
| notifyQueue | output | IDX_W | Queue that notified |
| notifyEsc | output | 1 | 1 when the escalation page notified |

## Verification
Some properties are checked on every cycle. A response must follow every request by exactly one cycle, and no response may appear without a request. An error must never coincide with a notify. Wrong-size loads must return all ones, and an inject on an escalation page must be refused. The state-transition tables need the bench's sequences to show them, because a correct value only appears when a later query reads it back. The same holds for the independence of the two pages and of separate queues, for the disabled and out-of-range queues, and for operation with 64 KiB pages.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_TRIG   = 3'd0,
    OP_EOI    = 3'd1,
    OP_QUERY  = 3'd2,
    OP_SET    = 3'd3,
    OP_INJECT = 3'd4
  } esbOp_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       fire;
    logic       bad;
    logic       isLoad;
    logic       esc;
    esbOp_e     op;
    logic [1:0] setVal;
  } esbStrobe_t;

  // {notify, next state}
  function automatic logic [2:0] pqTrigger(logic [1:0] pq);
    case (pq)
      2'b00:   return {1'b1, 2'b10};
      2'b10:   return {1'b0, 2'b11};
      default: return {1'b0, pq};
    endcase
  endfunction

  function automatic logic [2:0] pqEoi(logic [1:0] pq);
    case (pq)
      2'b10:   return {1'b0, 2'b00};
      2'b11:   return {1'b1, 2'b10};
      default: return {1'b0, pq};
    endcase
  endfunction

endpackage

// File: rtl/esb_ctrl.sv
module esb_ctrl
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_QUEUES = 12,
  parameter int IDX_W      = 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [3:0]        reqBytes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NUM_QUEUES-1:0] qEnable,
  output esbStrobe_t        strobe,
  output logic [IDX_W-1:0]  qIdx
);

  localparam int FIELD_W = ADDR_W - PAGE_SHIFT - 1;

  generate
    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_badShift
      $error("page shift must be 12 or 16");
    end
    if (FIELD_W < IDX_W) begin : g_badWidth
      $error("address too narrow for the queue count");
    end
  endgenerate

  logic [FIELD_W-1:0] fullIdx;
  logic [11:0]        offset;
  logic               inRange;
  logic               enabled;
  logic               escPage;
  logic               unusedAddr;

  assign fullIdx    = reqAddr[ADDR_W-1:PAGE_SHIFT+1];
  assign qIdx       = fullIdx[IDX_W-1:0];
  assign offset     = reqAddr[11:0];
  assign escPage    = reqAddr[PAGE_SHIFT];
  assign unusedAddr = ^reqAddr;
  assign inRange    = ({{(32-FIELD_W){1'b0}}, fullIdx} < 32'(NUM_QUEUES));

  always_comb begin
    enabled = 1'b0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (qIdx == IDX_W'(i)) enabled = qEnable[i];
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.fire   = reqValid;
    strobe.isLoad = !reqWrite;
    strobe.esc    = escPage;
    strobe.setVal = offset[9:8];
    strobe.bad    = !inRange || !enabled || (reqBytes != 4'd8);
    if (!reqWrite) begin
      case (offset[11:10])
        2'b00, 2'b01: strobe.op = OP_EOI;
        2'b10:        strobe.op = OP_QUERY;
        default:      strobe.op = OP_SET;
      endcase
    end else begin
      case (offset[11:10])
        2'b00: strobe.op = OP_TRIG;
        2'b01: strobe.op = OP_EOI;
        2'b10: begin
          strobe.op = OP_INJECT;
          if (escPage) strobe.bad = 1'b1;
        end
        default: begin
          strobe.op  = OP_TRIG;
          strobe.bad = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/esb_datapath.sv
module esb_datapath
  import esb_pkg::*;
#(
  parameter int NUM_QUEUES = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  esbStrobe_t       strobe,
  input  logic [IDX_W-1:0] qIdx,
  output logic             rspValid,
  output logic             rspErr,
  output logic [63:0]      rspData,
  output logic             notifyValid,
  output logic [IDX_W-1:0] notifyQueue,
  output logic             notifyEsc
);

  logic [1:0]       pqMem [NUM_QUEUES][2];
  logic [IDX_W-1:0] safeIdx;
  logic [1:0]       oldPq;
  logic [1:0]       newPq;
  logic [1:0]       loadVal;
  logic             ntf;
  logic             accept;
  logic [2:0]       stepRes;

  assign accept  = strobe.fire && !strobe.bad;
  assign safeIdx = strobe.bad ? '0 : qIdx;
  assign oldPq   = pqMem[safeIdx][strobe.esc];

  always_comb begin
    newPq   = oldPq;
    ntf     = 1'b0;
    loadVal = oldPq;
    stepRes = '0;
    case (strobe.op)
      OP_TRIG: begin
        stepRes = pqTrigger(oldPq);
        {ntf, newPq} = stepRes;
      end
      OP_EOI: begin
        stepRes = pqEoi(oldPq);
        {ntf, newPq} = stepRes;
        loadVal = {1'b0, stepRes[2]};
      end
      OP_SET:    newPq = strobe.setVal;
      OP_INJECT: ntf = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        for (int p = 0; p < 2; p++) pqMem[q][p] <= 2'b00;
      end
    end else if (accept && newPq != oldPq) begin
      pqMem[safeIdx][strobe.esc] <= newPq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      rspData     <= '0;
      notifyValid <= 1'b0;
      notifyQueue <= '0;
      notifyEsc   <= 1'b0;
    end else begin
      rspValid    <= strobe.fire;
      rspErr      <= strobe.fire && strobe.bad;
      notifyValid <= accept && ntf;
      notifyQueue <= qIdx;
      notifyEsc   <= strobe.esc;
      if (strobe.fire && strobe.bad && strobe.isLoad) rspData <= '1;
      else if (accept && strobe.isLoad)               rspData <= {62'd0, loadVal};
      else                                            rspData <= '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> !rspValid);
  // R11
  err_has_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);
  // R11
  err_no_notify_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> !notifyValid);
  // R5
  query_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && strobe.op == OP_QUERY) |=> !notifyValid);
  // R13
  notify_in_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> rspValid);

endmodule

// File: rtl/esb_mmio_ctrl.sv
module esb_mmio_ctrl
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_QUEUES = 12,
  localparam int IDX_W     = $clog2(NUM_QUEUES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_QUEUES-1:0] qEnable,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [3:0]            reqBytes,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [63:0]           rspData,
  output logic                  notifyValid,
  output logic [IDX_W-1:0]      notifyQueue,
  output logic                  notifyEsc
);

  esbStrobe_t       strobe;
  logic [IDX_W-1:0] qIdx;

  esb_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_QUEUES(NUM_QUEUES), .IDX_W(IDX_W)
  ) i_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBytes(reqBytes),
    .reqAddr(reqAddr), .qEnable(qEnable), .strobe(strobe), .qIdx(qIdx)
  );

  esb_datapath #(.NUM_QUEUES(NUM_QUEUES), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qIdx(qIdx),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .notifyValid(notifyValid), .notifyQueue(notifyQueue), .notifyEsc(notifyEsc)
  );

  // R11
  bad_size_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqBytes != 4'd8) |=> (rspErr && rspData == '1));
  // R10
  esc_inject_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr[PAGE_SHIFT] && reqAddr[11:10] == 2'b10)
      |=> (rspErr && !notifyValid));

endmodule

// File: tb/test_esb_mmio_ctrl.sv
`timescale 1ns/1ps
module test_esb_mmio_ctrl;

  typedef struct packed {
    logic        wr;
    logic [3:0]  bytes;
    logic [19:0] addr;
    logic [63:0] data;
    logic        err;
    logic        nv;
    logic [3:0]  nq;
    logic        ne;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd8, 20'h00800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 0  R1 R5
    '{1'b1, 4'd8, 20'h00000, 64'd0, 1'b0, 1'b1, 4'd0, 1'b0}, // 1  R7 00->10
    '{1'b0, 4'd8, 20'h00800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 2
    '{1'b1, 4'd8, 20'h00000, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 3  R7 10->11
    '{1'b0, 4'd8, 20'h00800, 64'd3, 1'b0, 1'b0, 4'd0, 1'b0}, // 4
    '{1'b1, 4'd8, 20'h00000, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 5  R7 11 stays
    '{1'b0, 4'd8, 20'h00800, 64'd3, 1'b0, 1'b0, 4'd0, 1'b0}, // 6
    '{1'b0, 4'd8, 20'h00000, 64'd1, 1'b0, 1'b1, 4'd0, 1'b0}, // 7  R4 11->10
    '{1'b0, 4'd8, 20'h00800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 8
    '{1'b0, 4'd8, 20'h00000, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 9  R4 10->00
    '{1'b0, 4'd8, 20'h00800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 10
    '{1'b0, 4'd8, 20'h01800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 11 R3
    '{1'b0, 4'd8, 20'h01D00, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 12 R6 set 01
    '{1'b1, 4'd8, 20'h01000, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 13 R7 01 stays
    '{1'b0, 4'd8, 20'h01800, 64'd1, 1'b0, 1'b0, 4'd0, 1'b0}, // 14
    '{1'b0, 4'd8, 20'h00800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 15 R3 pages apart
    '{1'b0, 4'd8, 20'h06F00, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 16 R6 set 11
    '{1'b1, 4'd8, 20'h06400, 64'd0, 1'b0, 1'b1, 4'd3, 1'b0}, // 17 R8
    '{1'b0, 4'd8, 20'h06800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 18
    '{1'b1, 4'd8, 20'h06800, 64'd0, 1'b0, 1'b1, 4'd3, 1'b0}, // 19 R9
    '{1'b0, 4'd8, 20'h06800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 20 R9 unchanged
    '{1'b1, 4'd8, 20'h01800, 64'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // 21 R10
    '{1'b0, 4'd8, 20'h01800, 64'd1, 1'b0, 1'b0, 4'd0, 1'b0}, // 22 R10 unchanged
    '{1'b1, 4'd8, 20'h06C00, 64'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // 23 R11 bad offset
    '{1'b0, 4'd8, 20'h06800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 24
    '{1'b0, 4'd8, 20'h18800, ONES,  1'b1, 1'b0, 4'd0, 1'b0}, // 25 R11 queue 12
    '{1'b1, 4'd8, 20'h18000, 64'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // 26 R11
    '{1'b0, 4'd4, 20'h06800, ONES,  1'b1, 1'b0, 4'd0, 1'b0}, // 27 R11 size
    '{1'b1, 4'd4, 20'h06000, 64'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // 28 R11 size
    '{1'b0, 4'd8, 20'h06800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 29
    '{1'b0, 4'd8, 20'h0A800, ONES,  1'b1, 1'b0, 4'd0, 1'b0}, // 30 R11 disabled
    '{1'b1, 4'd8, 20'h0B000, 64'd0, 1'b1, 1'b0, 4'd0, 1'b0}, // 31 R11 disabled
    '{1'b1, 4'd8, 20'h05000, 64'd0, 1'b0, 1'b1, 4'd2, 1'b1}, // 32 R13
    '{1'b0, 4'd8, 20'h05000, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 33 R4
    '{1'b0, 4'd8, 20'h05800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 34
    '{1'b0, 4'd8, 20'h04E00, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 35 R6 set 10
    '{1'b0, 4'd8, 20'h04800, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 36
    '{1'b0, 4'd8, 20'h04C00, 64'd2, 1'b0, 1'b0, 4'd0, 1'b0}, // 37 R6 set 00
    '{1'b0, 4'd8, 20'h04800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 38
    '{1'b1, 4'd8, 20'h01400, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 39 R8 01 stays
    '{1'b0, 4'd8, 20'h01800, 64'd1, 1'b0, 1'b0, 4'd0, 1'b0}, // 40
    '{1'b0, 4'd8, 20'h067FF, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}, // 41 R4 top of range
    '{1'b0, 4'd8, 20'h06800, 64'd0, 1'b0, 1'b0, 4'd0, 1'b0}  // 42
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] qEnable = 12'hFDF; // queue 5 disabled
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqBytes = 4'd8;
  logic [19:0] reqAddr = '0;
  logic        rspValid, rspErr, notifyValid, notifyEsc;
  logic [63:0] rspData;
  logic [3:0]  notifyQueue;

  logic        wReqValid = 1'b0;
  logic        wReqWrite = 1'b0;
  logic [23:0] wReqAddr = '0;
  logic        wRspValid, wRspErr, wNotifyValid, wNotifyEsc;
  logic [63:0] wRspData;
  logic [1:0]  wNotifyQueue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  esb_mmio_ctrl i_esb_mmio_ctrl (
    .clk(clk), .rstN(rstN), .qEnable(qEnable), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqBytes(reqBytes), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .notifyValid(notifyValid), .notifyQueue(notifyQueue), .notifyEsc(notifyEsc)
  );

  esb_mmio_ctrl #(.ADDR_W(24), .PAGE_SHIFT(16), .NUM_QUEUES(4)) i_esb_mmio_ctrl_wide (
    .clk(clk), .rstN(rstN), .qEnable(4'hF), .reqValid(wReqValid),
    .reqWrite(wReqWrite), .reqBytes(4'd8), .reqAddr(wReqAddr),
    .rspValid(wRspValid), .rspErr(wRspErr), .rspData(wRspData),
    .notifyValid(wNotifyValid), .notifyQueue(wNotifyQueue), .notifyEsc(wNotifyEsc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request, checked one cycle later at the following negedge
  task automatic access(input logic wr, input logic [3:0] bytes, input logic [19:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBytes = bytes; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle after reset
    chk(!rspValid && !notifyValid, "R1 idle outputs", {62'd0, rspValid, notifyValid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].bytes, VEC[i].addr);
      // R2 response timing, plus data/err/notify from the vector
      chk(rspValid, $sformatf("R2 vec %0d rspValid", i), {63'd0, rspValid}, 64'd1);
      chk(rspData == VEC[i].data, $sformatf("vec %0d data", i), rspData, VEC[i].data);
      chk(rspErr == VEC[i].err, $sformatf("vec %0d err", i), {63'd0, rspErr}, {63'd0, VEC[i].err});
      chk(notifyValid == VEC[i].nv, $sformatf("vec %0d notify", i),
          {63'd0, notifyValid}, {63'd0, VEC[i].nv});
      if (VEC[i].nv)
        chk({notifyQueue, notifyEsc} == {VEC[i].nq, VEC[i].ne},
            $sformatf("R13 vec %0d notify target", i),
            {59'd0, notifyQueue, notifyEsc}, {59'd0, VEC[i].nq, VEC[i].ne});
      @(negedge clk);
      // R2 single-cycle response
      chk(!rspValid && !notifyValid, $sformatf("R2 vec %0d pulse", i),
          {62'd0, rspValid, notifyValid}, 64'd0);
    end

    // R2 back-to-back: trigger on queue 7 then query in the next cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqBytes = 4'd8; reqAddr = 20'h0E000;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = 20'h0E800;
    chk(rspValid && notifyValid && notifyQueue == 4'd7, "R2 back-to-back first",
        {59'd0, notifyQueue, notifyValid}, {59'd0, 4'd7, 1'b1});
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid && rspData == 64'd2, "R2 back-to-back second", rspData, 64'd2);

    // R12 wide pages: shift 16, queue 1 escalation page
    @(negedge clk);
    wReqValid = 1'b1; wReqWrite = 1'b1; wReqAddr = 24'h030000;
    @(negedge clk);
    wReqValid = 1'b0;
    chk(wNotifyValid && wNotifyQueue == 2'd1 && wNotifyEsc, "R12 wide trigger",
        {61'd0, wNotifyQueue, wNotifyEsc}, {61'd0, 2'd1, 1'b1});
    @(negedge clk);
    wReqValid = 1'b1; wReqWrite = 1'b0; wReqAddr = 24'h030800;
    @(negedge clk);
    wReqValid = 1'b0;
    chk(wRspData == 64'd2 && !wRspErr, "R12 wide query esc", wRspData, 64'd2);
    @(negedge clk);
    wReqValid = 1'b1; wReqWrite = 1'b0; wReqAddr = 24'h020800;
    @(negedge clk);
    wReqValid = 1'b0;
    chk(wRspData == 64'd0, "R12 wide query notif page", wRspData, 64'd0);
    @(negedge clk);
    // bit 12 is inside the page when the shift is 16: queue 0 notification page
    wReqValid = 1'b1; wReqWrite = 1'b1; wReqAddr = 24'h001000;
    @(negedge clk);
    wReqValid = 1'b0;
    chk(wNotifyValid && wNotifyQueue == 2'd0 && !wNotifyEsc, "R12 wide offset bit12",
        {61'd0, wNotifyQueue, wNotifyEsc}, {61'd0, 2'd0, 1'b0});

    // R1 reset clears state
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 4'd8, 20'h06F00 ^ 20'h00700); // query queue 3
    chk(rspData == 64'd0, "R1 state cleared", rspData, 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule